// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block is an eight-entry store buffer that answers byte-forwarding queries from a two-stage load pipeline. Stores fill an entry in two steps. An address write records the virtual address, the physical address and the 16-bit byte-enable mask, and marks the address known. A data write records the 16 data bytes and marks the data ready. A free operation returns the entry to the empty state.

A load presents its virtual address, physical address, byte mask and a window mask. The window mask has one bit per entry and marks the stores that are older than the load. In the load's first stage the block returns, in the same cycle, a fast forward mask and a fast data-not-ready flag. One cycle later it returns registered copies of the full result: the forward mask, the forwarded bytes, and three failure indications, each of which the load pipeline acts on separately. Address-unknown and data-not-ready each carry an entry index so that the scheduler can replay the load. Virtual/physical disagreement requests a pipeline flush.

Within the window, a higher entry index means a younger store. For each byte lane, the youngest matching store supplies the byte.

Top module: `sfwd_lookup`

## Requirements
- R1: While reset is asserted and after it is released, every entry is empty (address and data not known). With no query pending, all stage-2 outputs are zero.
- R2: An address write sets the entry's virtual address, physical address and byte mask, and marks the address known. A data write sets the entry's 16 data bytes, with byte j in bits [8j+7:8j], and marks the data ready. A free clears both marks and wins over a write to the same entry in the same cycle. A query sees the entry state from before the clock edge on which it is presented.
- R3: An entry matches a load only when the entry is inside the window, its address is known, address bits above bit 3 (the 16-byte line) are equal, and its byte mask overlaps the load's byte mask. Virtual and physical matches are evaluated separately.
- R4: For each lane j with load mask bit j set, the highest-indexed physically matching entry that has mask bit j set is selected. If that entry's data is ready, forward mask bit j is 1 and forward byte j is that entry's byte j. In every other case, mask bit j is 0 and byte j is 0x00.
- R5: If the store selected for any lane has no data yet, data-invalid is 1. Its index output is the highest such entry index, and 0 when the flag is low.
- R6: If any entry in the window has an unknown address, address-invalid is 1. Its index output is the highest such entry index, and 0 when the flag is low.
- R7: Match-invalid is 1 when the set of entries matched by virtual address differs from the set matched by physical address.
- R8: The fast forward mask and fast data-invalid flag are combinational, and equal the forward mask and data-invalid values for the query in the same cycle.
- R9: The stage-2 outputs present the result of the query made one clock earlier, computed from the state at that earlier edge.
- R10: A query with its valid input low gives zero masks, zero data and deasserted flags in both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_en | input | 1 | Address write strobe |
| aw_idx | input | 3 | Entry written with an address |
| aw_va | input | 32 | Store virtual address |
| aw_pa | input | 32 | Store physical address |
| aw_mask | input | 16 | Store byte-enable mask |
| dw_en | input | 1 | Data write strobe |
| dw_idx | input | 3 | Entry written with data |
| dw_data | input | 128 | Store data, byte j in bits [8j+7:8j] |
| fr_en | input | 1 | Free strobe |
| fr_idx | input | 3 | Entry freed |
| ld_valid | input | 1 | Query valid |
| ld_va | input | 32 | Load virtual address |
| ld_pa | input | 32 | Load physical address |
| ld_mask | input | 16 | Load byte mask |
| ld_older | input | 8 | Window of older stores, one bit per entry |
| fast_fwd_mask | output | 16 | Stage-1 forward mask |
| fast_data_inv | output | 1 | Stage-1 data-not-ready flag |
| fwd_mask | output | 16 | Stage-2 forward mask |
| fwd_data | output | 128 | Stage-2 forwarded bytes |
| data_inv | output | 1 | Stage-2 data-not-ready flag |
| data_inv_idx | output | 3 | Entry lacking data |
| addr_inv | output | 1 | Stage-2 address-unknown flag |
| addr_inv_idx | output | 3 | Entry with unknown address |
| match_inv | output | 1 | Stage-2 virtual/physical disagreement |

## Verification
The assertions assume that every input is a known value at each clock edge after reset. They also assume that the query inputs are held low while reset is asserted, so the stage pipe starts from zeroed results. The stimulus drives every input on the falling edge and keeps the query idle during reset. It draws addresses from a small pool of lines so that entries collide often. The physical address usually follows a fixed translation of the virtual line and occasionally aliases another line, so that virtual/physical disagreement occurs. Window masks are arbitrary, and non-contiguous masks are included, so the youngest-store selection is exercised across gaps.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
    localparam int unsigned SF_ENTRIES = 8;
    localparam int unsigned SF_BYTES   = 16;
    localparam int unsigned SF_VA_W    = 32;
    localparam int unsigned SF_PA_W    = 32;
endpackage

// File: rtl/sfwd_store_table.sv
module sfwd_store_table #(
    parameter int unsigned NENT = sfwd_pkg::SF_ENTRIES,
    parameter int unsigned NB   = sfwd_pkg::SF_BYTES,
    parameter int unsigned VA_W = sfwd_pkg::SF_VA_W,
    parameter int unsigned PA_W = sfwd_pkg::SF_PA_W,
    localparam int unsigned IW  = $clog2(NENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           aw_en,
    input  logic [IW-1:0]                  aw_idx,
    input  logic [VA_W-1:0]                aw_va,
    input  logic [PA_W-1:0]                aw_pa,
    input  logic [NB-1:0]                  aw_mask,
    input  logic                           dw_en,
    input  logic [IW-1:0]                  dw_idx,
    input  logic [NB*8-1:0]                dw_data,
    input  logic                           fr_en,
    input  logic [IW-1:0]                  fr_idx,
    output logic [NENT-1:0]                ent_av,
    output logic [NENT-1:0]                ent_dv,
    output logic [NENT-1:0][VA_W-1:0]      ent_va,
    output logic [NENT-1:0][PA_W-1:0]      ent_pa,
    output logic [NENT-1:0][NB-1:0]        ent_msk,
    output logic [NENT-1:0][NB*8-1:0]      ent_dat
);
    typedef struct packed {
        logic [NENT-1:0]           av;
        logic [NENT-1:0]           dv;
        logic [NENT-1:0][VA_W-1:0] va;
        logic [NENT-1:0][PA_W-1:0] pa;
        logic [NENT-1:0][NB-1:0]   msk;
        logic [NENT-1:0][NB*8-1:0] dat;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (aw_en) begin
            tbl_d.va[aw_idx]  = aw_va;
            tbl_d.pa[aw_idx]  = aw_pa;
            tbl_d.msk[aw_idx] = aw_mask;
            tbl_d.av[aw_idx]  = 1'b1;
        end
        if (dw_en) begin
            tbl_d.dat[dw_idx] = dw_data;
            tbl_d.dv[dw_idx]  = 1'b1;
        end
        if (fr_en) begin
            tbl_d.av[fr_idx] = 1'b0;
            tbl_d.dv[fr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign ent_av  = tbl_q.av;
    assign ent_dv  = tbl_q.dv;
    assign ent_va  = tbl_q.va;
    assign ent_pa  = tbl_q.pa;
    assign ent_msk = tbl_q.msk;
    assign ent_dat = tbl_q.dat;

    // R2
    free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_en |=> (!ent_av[$past(fr_idx)] && !ent_dv[$past(fr_idx)]));

    // R2
    addr_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_en && !(fr_en && fr_idx == aw_idx)) |=> ent_av[$past(aw_idx)]);
endmodule

// File: rtl/sfwd_match.sv
module sfwd_match #(
    parameter int unsigned NENT = sfwd_pkg::SF_ENTRIES,
    parameter int unsigned NB   = sfwd_pkg::SF_BYTES,
    parameter int unsigned VA_W = sfwd_pkg::SF_VA_W,
    parameter int unsigned PA_W = sfwd_pkg::SF_PA_W,
    localparam int unsigned OFF_W = $clog2(NB)
) (
    input  logic                      ld_valid,
    input  logic [VA_W-1:0]           ld_va,
    input  logic [PA_W-1:0]           ld_pa,
    input  logic [NB-1:0]             ld_mask,
    input  logic [NENT-1:0]           ld_older,
    input  logic [NENT-1:0]           ent_av,
    input  logic [NENT-1:0][VA_W-1:0] ent_va,
    input  logic [NENT-1:0][PA_W-1:0] ent_pa,
    input  logic [NENT-1:0][NB-1:0]   ent_msk,
    output logic [NENT-1:0]           vhit,
    output logic [NENT-1:0]           phit,
    output logic [NENT-1:0]           unknown
);
    for (genvar i = 0; i < NENT; i++) begin : g_ent
        logic live;
        logic overlap;
        assign live       = ld_valid & ld_older[i];
        assign overlap    = |(ent_msk[i] & ld_mask);
        assign vhit[i]    = live & ent_av[i] & overlap &
                            (ent_va[i][VA_W-1:OFF_W] == ld_va[VA_W-1:OFF_W]);
        assign phit[i]    = live & ent_av[i] & overlap &
                            (ent_pa[i][PA_W-1:OFF_W] == ld_pa[PA_W-1:OFF_W]);
        assign unknown[i] = live & ~ent_av[i];
    end
endmodule

// File: rtl/sfwd_lane_pick.sv
module sfwd_lane_pick #(
    parameter int unsigned NENT = sfwd_pkg::SF_ENTRIES,
    parameter int unsigned NB   = sfwd_pkg::SF_BYTES,
    localparam int unsigned IW  = $clog2(NENT)
) (
    input  logic [NENT-1:0]           phit,
    input  logic [NB-1:0]             ld_mask,
    input  logic [NENT-1:0]           ent_dv,
    input  logic [NENT-1:0][NB-1:0]   ent_msk,
    input  logic [NENT-1:0][NB*8-1:0] ent_dat,
    output logic [NB-1:0]             fmask,
    output logic [NB*8-1:0]           fdata,
    output logic [NENT-1:0]           pend
);
    logic [NENT-1:0] lane_wait [NB];

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic          hit;
        logic [IW-1:0] win;
        always_comb begin
            hit = 1'b0;
            win = '0;
            for (int i = 0; i < NENT; i++) begin
                if (phit[i] && ent_msk[i][j] && ld_mask[j]) begin
                    hit = 1'b1;
                    win = IW'(i);
                end
            end
        end
        assign fmask[j]         = hit & ent_dv[win];
        assign fdata[8*j +: 8]  = fmask[j] ? ent_dat[win][8*j +: 8] : 8'h00;
        assign lane_wait[j]     = (hit & ~ent_dv[win]) ? (NENT'(1) << win) : '0;
    end

    always_comb begin
        pend = '0;
        for (int j = 0; j < NB; j++) pend = pend | lane_wait[j];
    end
endmodule

// File: rtl/sfwd_lookup.sv
module sfwd_lookup #(
    parameter int unsigned NENT = sfwd_pkg::SF_ENTRIES,
    parameter int unsigned NB   = sfwd_pkg::SF_BYTES,
    parameter int unsigned VA_W = sfwd_pkg::SF_VA_W,
    parameter int unsigned PA_W = sfwd_pkg::SF_PA_W,
    localparam int unsigned IW  = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_en,
    input  logic [IW-1:0]    aw_idx,
    input  logic [VA_W-1:0]  aw_va,
    input  logic [PA_W-1:0]  aw_pa,
    input  logic [NB-1:0]    aw_mask,
    input  logic             dw_en,
    input  logic [IW-1:0]    dw_idx,
    input  logic [NB*8-1:0]  dw_data,
    input  logic             fr_en,
    input  logic [IW-1:0]    fr_idx,
    input  logic             ld_valid,
    input  logic [VA_W-1:0]  ld_va,
    input  logic [PA_W-1:0]  ld_pa,
    input  logic [NB-1:0]    ld_mask,
    input  logic [NENT-1:0]  ld_older,
    output logic [NB-1:0]    fast_fwd_mask,
    output logic             fast_data_inv,
    output logic [NB-1:0]    fwd_mask,
    output logic [NB*8-1:0]  fwd_data,
    output logic             data_inv,
    output logic [IW-1:0]    data_inv_idx,
    output logic             addr_inv,
    output logic [IW-1:0]    addr_inv_idx,
    output logic             match_inv
);
    typedef struct packed {
        logic [NB-1:0]   fmask;
        logic [NB*8-1:0] fdata;
        logic            dinv;
        logic [IW-1:0]   didx;
        logic            ainv;
        logic [IW-1:0]   aidx;
        logic            minv;
    } res_t;

    logic [NENT-1:0]           ent_av, ent_dv;
    logic [NENT-1:0][VA_W-1:0] ent_va;
    logic [NENT-1:0][PA_W-1:0] ent_pa;
    logic [NENT-1:0][NB-1:0]   ent_msk;
    logic [NENT-1:0][NB*8-1:0] ent_dat;
    logic [NENT-1:0]           vhit, phit, unknown, pend;
    logic [NB-1:0]             pick_mask;
    logic [NB*8-1:0]           pick_data;
    res_t                      res_d, res_q;

    sfwd_store_table #(.NENT(NENT), .NB(NB), .VA_W(VA_W), .PA_W(PA_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .aw_en(aw_en), .aw_idx(aw_idx), .aw_va(aw_va), .aw_pa(aw_pa), .aw_mask(aw_mask),
        .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
        .fr_en(fr_en), .fr_idx(fr_idx),
        .ent_av(ent_av), .ent_dv(ent_dv), .ent_va(ent_va), .ent_pa(ent_pa),
        .ent_msk(ent_msk), .ent_dat(ent_dat)
    );

    sfwd_match #(.NENT(NENT), .NB(NB), .VA_W(VA_W), .PA_W(PA_W)) u_match (
        .ld_valid(ld_valid), .ld_va(ld_va), .ld_pa(ld_pa), .ld_mask(ld_mask),
        .ld_older(ld_older), .ent_av(ent_av), .ent_va(ent_va), .ent_pa(ent_pa),
        .ent_msk(ent_msk), .vhit(vhit), .phit(phit), .unknown(unknown)
    );

    sfwd_lane_pick #(.NENT(NENT), .NB(NB)) u_pick (
        .phit(phit), .ld_mask(ld_mask), .ent_dv(ent_dv), .ent_msk(ent_msk),
        .ent_dat(ent_dat), .fmask(pick_mask), .fdata(pick_data), .pend(pend)
    );

    always_comb begin
        res_d       = '0;
        res_d.fmask = pick_mask;
        res_d.fdata = pick_data;
        res_d.dinv  = |pend;
        res_d.ainv  = |unknown;
        res_d.minv  = |(vhit ^ phit);
        for (int i = 0; i < NENT; i++) begin
            if (pend[i])    res_d.didx = IW'(i);
            if (unknown[i]) res_d.aidx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign fast_fwd_mask = res_d.fmask;
    assign fast_data_inv = res_d.dinv;
    assign fwd_mask      = res_q.fmask;
    assign fwd_data      = res_q.fdata;
    assign data_inv      = res_q.dinv;
    assign data_inv_idx  = res_q.didx;
    assign addr_inv      = res_q.ainv;
    assign addr_inv_idx  = res_q.aidx;
    assign match_inv     = res_q.minv;

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (fast_fwd_mask == '0 && !fast_data_inv));

    // R9
    stage_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (fwd_mask == $past(fast_fwd_mask) && data_inv == $past(fast_data_inv)));

    // R4
    mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((fwd_mask & ~$past(ld_mask)) == '0));

    // R5
    dinv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_data_inv |-> (ld_valid && ld_older[res_d.didx]));

    // R6
    ainv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.ainv |-> (ld_valid && ld_older[res_d.aidx] && !ent_av[res_d.aidx]));
endmodule

// File: tb/tb_sfwd_lookup.sv
module tb_sfwd_lookup;
    localparam int NENT = 8;
    localparam int NB   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          aw_en = 0, dw_en = 0, fr_en = 0, ld_valid = 0;
    logic [2:0]    aw_idx = 0, dw_idx = 0, fr_idx = 0;
    logic [31:0]   aw_va = 0, aw_pa = 0, ld_va = 0, ld_pa = 0;
    logic [15:0]   aw_mask = 0, ld_mask = 0;
    logic [127:0]  dw_data = 0;
    logic [7:0]    ld_older = 0;
    logic [15:0]   fast_fwd_mask, fwd_mask;
    logic          fast_data_inv, data_inv, addr_inv, match_inv;
    logic [127:0]  fwd_data;
    logic [2:0]    data_inv_idx, addr_inv_idx;

    int checks = 0, failures = 0;
    bit done = 0;

    sfwd_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .aw_en(aw_en), .aw_idx(aw_idx), .aw_va(aw_va), .aw_pa(aw_pa), .aw_mask(aw_mask),
        .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
        .fr_en(fr_en), .fr_idx(fr_idx),
        .ld_valid(ld_valid), .ld_va(ld_va), .ld_pa(ld_pa), .ld_mask(ld_mask), .ld_older(ld_older),
        .fast_fwd_mask(fast_fwd_mask), .fast_data_inv(fast_data_inv),
        .fwd_mask(fwd_mask), .fwd_data(fwd_data), .data_inv(data_inv),
        .data_inv_idx(data_inv_idx), .addr_inv(addr_inv), .addr_inv_idx(addr_inv_idx),
        .match_inv(match_inv)
    );

    always #5 clk = ~clk;

    // behavioural model state
    bit          m_av [NENT];
    bit          m_dv [NENT];
    logic [31:0] m_va [NENT];
    logic [31:0] m_pa [NENT];
    logic [15:0] m_msk [NENT];
    logic [7:0]  m_dat [NENT][NB];

    // expected results (current query, and the one registered for stage 2)
    logic [15:0]  e_mask, s_mask;
    logic [127:0] e_data, s_data;
    bit           e_dinv, s_dinv, e_ainv, s_ainv, e_minv, s_minv;
    int           e_didx, s_didx, e_aidx, s_aidx;

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic calc();
        int best;
        e_mask = '0; e_data = '0; e_ainv = 0; e_aidx = 0; e_minv = 0;
        best = -1;
        if (ld_valid) begin
            for (int i = 0; i < NENT; i++) begin
                if (ld_older[i]) begin
                    if (!m_av[i]) begin
                        e_ainv = 1; e_aidx = i;
                    end else begin
                        bit ov, vm, pm;
                        ov = (m_msk[i] & ld_mask) != 0;
                        vm = ov && (m_va[i][31:4] == ld_va[31:4]);
                        pm = ov && (m_pa[i][31:4] == ld_pa[31:4]);
                        if (vm != pm) e_minv = 1;
                    end
                end
            end
            for (int j = 0; j < NB; j++) begin
                bit found;
                found = 0;
                for (int i = NENT - 1; i >= 0; i--) begin
                    if (!found && ld_older[i] && m_av[i] && ld_mask[j] && m_msk[i][j] &&
                        (m_pa[i][31:4] == ld_pa[31:4])) begin
                        found = 1;
                        if (m_dv[i]) begin
                            e_mask[j] = 1'b1;
                            e_data[8*j +: 8] = m_dat[i][j];
                        end else if (i > best) best = i;
                    end
                end
            end
        end
        e_dinv = (best >= 0);
        e_didx = (best >= 0) ? best : 0;
    endtask

    task automatic check_stage2();
        chk("R4/R9", "fwd_mask", 128'(fwd_mask), 128'(s_mask));
        chk("R4", "fwd_data", fwd_data, s_data);
        chk("R5", "data_inv", 128'(data_inv), 128'(s_dinv));
        chk("R5", "data_inv_idx", 128'(data_inv_idx), 128'(s_didx));
        chk("R6", "addr_inv", 128'(addr_inv), 128'(s_ainv));
        chk("R6", "addr_inv_idx", 128'(addr_inv_idx), 128'(s_aidx));
        chk("R7", "match_inv", 128'(match_inv), 128'(s_minv));
    endtask

    // inputs already driven at a falling edge; ends at the next falling edge
    task automatic step();
        #1;
        calc();
        chk(ld_valid ? "R8" : "R10", "fast_fwd_mask", 128'(fast_fwd_mask), 128'(e_mask));
        chk(ld_valid ? "R8" : "R10", "fast_data_inv", 128'(fast_data_inv), 128'(e_dinv));
        @(posedge clk);
        s_mask = e_mask; s_data = e_data; s_dinv = e_dinv; s_didx = e_didx;
        s_ainv = e_ainv; s_aidx = e_aidx; s_minv = e_minv;
        if (aw_en) begin
            m_va[aw_idx] = aw_va; m_pa[aw_idx] = aw_pa; m_msk[aw_idx] = aw_mask; m_av[aw_idx] = 1;
        end
        if (dw_en) begin
            for (int j = 0; j < NB; j++) m_dat[dw_idx][j] = dw_data[8*j +: 8];
            m_dv[dw_idx] = 1;
        end
        if (fr_en) begin
            m_av[fr_idx] = 0; m_dv[fr_idx] = 0;
        end
        @(negedge clk);
        check_stage2();
    endtask

    task automatic idle_inputs();
        aw_en = 0; dw_en = 0; fr_en = 0; ld_valid = 0;
    endtask

    task automatic do_aw(int idx, logic [31:0] va, logic [31:0] pa, logic [15:0] m);
        idle_inputs();
        aw_en = 1; aw_idx = 3'(idx); aw_va = va; aw_pa = pa; aw_mask = m;
        step();
    endtask

    task automatic do_dw(int idx, logic [127:0] d);
        idle_inputs();
        dw_en = 1; dw_idx = 3'(idx); dw_data = d;
        step();
    endtask

    task automatic do_ld(logic [31:0] va, logic [31:0] pa, logic [15:0] m, logic [7:0] w);
        idle_inputs();
        ld_valid = 1; ld_va = va; ld_pa = pa; ld_mask = m; ld_older = w;
        step();
    endtask

    function automatic logic [31:0] xlate(logic [31:0] va);
        return va ^ 32'h8000_0000;
    endfunction

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_av[i] = 0; m_dv[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_msk[i] = 0;
            for (int j = 0; j < NB; j++) m_dat[i][j] = 0;
        end
        s_mask = 0; s_data = 0; s_dinv = 0; s_didx = 0; s_ainv = 0; s_aidx = 0; s_minv = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the outputs
        check_stage2();
        rst_n = 1;
        @(negedge clk);
        check_stage2();
        // R1: every entry starts empty, so a full window reports unknown address at entry 7
        do_ld(32'h1000, xlate(32'h1000), 16'hFFFF, 8'hFF);

        // R2/R4: two stores on one line, the younger one wins where masks overlap
        do_aw(2, 32'h1004, xlate(32'h1004), 16'h00FF);
        do_aw(5, 32'h1008, xlate(32'h1008), 16'h0FF0);
        do_dw(2, {16{8'hA2}});
        do_dw(5, {16{8'h5B}});
        do_ld(32'h1000, xlate(32'h1000), 16'hFFFF, 8'b0010_0100);
        // R4: window excluding entry 5 takes bytes only from entry 2
        do_ld(32'h1000, xlate(32'h1000), 16'hFFFF, 8'b0000_0100);
        // R3: different line, no match
        do_ld(32'h1010, xlate(32'h1010), 16'hFFFF, 8'b0010_0100);
        // R3: no mask overlap
        do_ld(32'h1000, xlate(32'h1000), 16'hF000, 8'b0010_0100);
        // R7: physical alias to the other line
        do_ld(32'h1000, xlate(32'h1010), 16'hFFFF, 8'b0010_0100);
        // R5: entry 6 address known, data missing
        do_aw(6, 32'h100C, xlate(32'h100C), 16'h3000);
        do_ld(32'h1000, xlate(32'h1000), 16'hFFFF, 8'b0110_0100);
        // R2: free wins over a same-cycle address write
        idle_inputs();
        aw_en = 1; aw_idx = 3'd5; aw_va = 32'h1000; aw_pa = xlate(32'h1000); aw_mask = 16'hFFFF;
        fr_en = 1; fr_idx = 3'd5;
        step();
        do_ld(32'h1000, xlate(32'h1000), 16'hFFFF, 8'b0010_0100);
        // R10: idle query with state present
        idle_inputs();
        ld_va = 32'h1000; ld_pa = xlate(32'h1000); ld_mask = 16'hFFFF; ld_older = 8'hFF;
        step();

        // R2/R9: random mix; queries see the state before each edge
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va;
            idle_inputs();
            aw_en = ($urandom_range(0, 9) < 4);
            aw_idx = 3'($urandom_range(0, 7));
            va = 32'h1000 + 32'($urandom_range(0, 2)) * 32'h10 + 32'($urandom_range(0, 15));
            aw_va = va;
            aw_pa = ($urandom_range(0, 9) == 0) ? xlate(va + 32'h10) : xlate(va);
            aw_mask = 16'($urandom);
            dw_en = ($urandom_range(0, 9) < 4);
            dw_idx = 3'($urandom_range(0, 7));
            dw_data = {$urandom, $urandom, $urandom, $urandom};
            fr_en = ($urandom_range(0, 9) < 2);
            fr_idx = 3'($urandom_range(0, 7));
            ld_valid = ($urandom_range(0, 9) < 7);
            va = 32'h1000 + 32'($urandom_range(0, 2)) * 32'h10;
            ld_va = va;
            ld_pa = ($urandom_range(0, 9) == 0) ? xlate(va + 32'h10) : xlate(va);
            ld_mask = ($urandom_range(0, 1) == 1) ? 16'hFFFF : 16'($urandom);
            ld_older = 8'($urandom);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule